// File: doc/BRIEF.md
# Idle Channel Code Inserter

This block sits in the transmit path of a 24-channel PCM stream. It overwrites the 8-bit content of chosen timeslots with a programmable idle code. Serial data arrives one bit per clock. A frame-sync input is high on the framing bit that starts each 193-bit frame. That framing bit is followed by 24 channels of 8 bits each, sent MSB first. The altered stream leaves one clock later, and the frame sync is delayed by the same amount.

A 24-bit channel-select mask and an 8-bit idle code are written through a small register port. Mask words only accept a write while two bank-enable inputs are both high. The idle code can be written at any time. Writes land in pending copies. The working copies take the pending values when a framing bit is seen, so a channel is never partly replaced.

Top module: `idle_code_inserter`

## Requirements
- R1: During and right after reset, `dout` and `dout_fs` are 0, the mask is all zeros and every channel passes through unchanged.
- R2: `dout` and `dout_fs` repeat `din` and `din_fs` with exactly one clock of latency, apart from the replaced bits.
- R3: The framing bit is the `din` bit sampled while `din_fs` is 1. It is never altered.
- R4: Channel k (k = 1..24) occupies frame bits 1+8(k-1) through 8k, where bit 0 is the framing bit. When mask bit k-1 is 1, those eight bits are replaced by the idle code, bit 7 first and bit 0 last.
- R5: A channel whose mask bit is 0 passes through unchanged.
- R6: On a clock edge where `wr_en` is 1, address 0 writes mask bits 7:0 (channels 1 to 8, with bit 0 for channel 1), address 1 writes channels 9 to 16, address 2 writes channels 17 to 24, and address 3 writes the idle code.
- R7: A write to addresses 0 to 2 is ignored unless `bank_a` and `bank_b` are both 1. A write to address 3 needs neither of them.
- R8: A written mask or code takes effect only from the framing bit that next arrives on `din_fs`. Bits of the frame already in progress keep the old values.
- R9: No bit is replaced before the first framing bit after reset. No bit is replaced after bit 192 of a frame until the next framing bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 to 2 for mask words, 3 for the idle code |
| wr_data | input | 8 | Write data |
| bank_a | input | 1 | First bank-enable bit for mask writes |
| bank_b | input | 1 | Second bank-enable bit for mask writes |
| din | input | 1 | Serial PCM input bit |
| din_fs | input | 1 | High on the framing bit of `din` |
| dout | output | 1 | Serial PCM output bit |
| dout_fs | output | 1 | Frame sync aligned to `dout` |

## Verification
The bench builds the block with its default parameters: 24 channels of 8 bits. This gives the full 193-bit frame, three mask words and the idle-code register at address 3. With these values the bench reaches both end channels (1 and 24), alternating mask patterns, writes refused by the bank enables, and writes landing in the middle of a frame. It also drives stretches before the first frame sync and past bit 192.

// File: rtl/idle_code_inserter.sv
module idle_code_inserter #(
  parameter int CHANNELS = 24,
  parameter int SLOT_W = 8,
  parameter logic [SLOT_W-1:0] CODE_RST = '0,
  localparam int MASK_WORDS = (CHANNELS + SLOT_W - 1) / SLOT_W,
  localparam int ADDR_W = $clog2(MASK_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [SLOT_W-1:0] wr_data,
  input  logic              bank_a,
  input  logic              bank_b,
  input  logic              din,
  input  logic              din_fs,
  output logic              dout,
  output logic              dout_fs
);
  localparam int FRAME_BITS = 1 + CHANNELS * SLOT_W;
  localparam int POS_W = $clog2(FRAME_BITS + 1);
  localparam int MASK_PAD = MASK_WORDS * SLOT_W;

  logic [MASK_PAD-1:0] pend_flat;
  logic [SLOT_W-1:0]   pend_code;
  logic [CHANNELS-1:0] act_mask;
  logic [SLOT_W-1:0]   act_code;
  logic [POS_W-1:0]    pos_q;
  logic [POS_W-1:0]    cur_pos;
  logic [POS_W-1:0]    idx;
  logic [POS_W-1:0]    ch;
  logic [POS_W-1:0]    bitn;
  logic [POS_W-1:0]    code_idx;
  logic                bank_ok;
  logic                in_payload;
  logic                replace;

  assign bank_ok = bank_a && bank_b;

  for (genvar w = 0; w < MASK_WORDS; w++) begin : g_word
    logic [SLOT_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        word_q <= '0;
      else if (wr_en && bank_ok && wr_addr == ADDR_W'(w))
        word_q <= wr_data;
    end
    assign pend_flat[w*SLOT_W +: SLOT_W] = word_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      pend_code <= CODE_RST;
    else if (wr_en && wr_addr == ADDR_W'(MASK_WORDS))
      pend_code <= wr_data;
  end

  assign cur_pos    = din_fs ? '0 : pos_q;
  assign in_payload = (cur_pos != '0) && (cur_pos < POS_W'(FRAME_BITS));
  assign idx        = cur_pos - 1'b1;
  assign ch         = idx / POS_W'(SLOT_W);
  assign bitn       = idx % POS_W'(SLOT_W);
  assign code_idx   = POS_W'(SLOT_W - 1) - bitn;
  assign replace    = in_payload && act_mask[ch];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q    <= POS_W'(FRAME_BITS);
      act_mask <= '0;
      act_code <= CODE_RST;
      dout     <= 1'b0;
      dout_fs  <= 1'b0;
    end else begin
      pos_q   <= (cur_pos == POS_W'(FRAME_BITS)) ? cur_pos : cur_pos + 1'b1;
      dout    <= replace ? act_code[code_idx] : din;
      dout_fs <= din_fs;
      if (din_fs) begin
        act_mask <= pend_flat[CHANNELS-1:0];
        act_code <= pend_code;
      end
    end
  end
endmodule

// File: rtl/idle_code_inserter_chk.sv
module idle_code_inserter_chk #(
  parameter int CHANNELS = 24,
  parameter int SLOT_W = 8,
  localparam int MASK_WORDS = (CHANNELS + SLOT_W - 1) / SLOT_W,
  localparam int ADDR_W = $clog2(MASK_WORDS + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic                bank_a,
  input logic                bank_b,
  input logic                din,
  input logic                din_fs,
  input logic                dout,
  input logic                dout_fs,
  input logic [CHANNELS-1:0] act_mask,
  input logic [CHANNELS-1:0] pend_mask
);
  // R2
  fs_delay_chk: assert property (@(posedge clk) disable iff (!rst_n) din_fs |=> dout_fs);
  // R2
  fs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !din_fs |=> !dout_fs);
  // R3
  framing_keep_chk: assert property (@(posedge clk) disable iff (!rst_n) din_fs |=> dout == $past(din));
  // R5
  clear_pass_chk: assert property (@(posedge clk) disable iff (!rst_n) (act_mask == '0) |=> dout == $past(din));
  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !din_fs |=> $stable(act_mask));
  // R7
  bank_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr < ADDR_W'(MASK_WORDS) && !(bank_a && bank_b)) |=> $stable(pend_mask));
endmodule

bind idle_code_inserter idle_code_inserter_chk #(.CHANNELS(CHANNELS), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .bank_a(bank_a), .bank_b(bank_b), .din(din), .din_fs(din_fs),
  .dout(dout), .dout_fs(dout_fs), .act_mask(act_mask),
  .pend_mask(pend_flat[CHANNELS-1:0])
);

// File: tb/idle_code_inserter_test.sv
module idle_code_inserter_test;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME = 193;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic bank_a = 1'b0, bank_b = 1'b0;
  logic din = 1'b0, din_fs = 1'b0;
  logic dout, dout_fs;

  always #(CLK_PERIOD/2) clk = ~clk;

  idle_code_inserter uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bank_a(bank_a), .bank_b(bank_b), .din(din), .din_fs(din_fs),
    .dout(dout), .dout_fs(dout_fs)
  );

  typedef struct {
    logic  b;
    logic  fs;
    string req;
  } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  bit done = 0;
  string ctx = "R1";

  bit [23:0] m_pmask = '0, m_amask = '0;
  bit [7:0]  m_pcode = '0, m_acode = '0;
  int        m_pos = FRAME;

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic d, input logic fs, input logic we, input logic [1:0] a,
                     input logic [7:0] data, input logic ba, input logic bb);
    exp_t e;
    int ch, bn;
    @(negedge clk);
    din = d; din_fs = fs; wr_en = we; wr_addr = a; wr_data = data; bank_a = ba; bank_b = bb;
    if (fs) begin
      m_pos = 0; m_amask = m_pmask; m_acode = m_pcode;
    end
    e.fs = fs;
    if (m_pos == 0) begin
      e.b = d; e.req = {"R3/", ctx};
    end else if (m_pos >= FRAME) begin
      e.b = d; e.req = {"R9/", ctx};
    end else begin
      ch = (m_pos - 1) / 8; bn = (m_pos - 1) % 8;
      if (m_amask[ch]) begin
        e.b = m_acode[7-bn]; e.req = {"R4/", ctx};
      end else begin
        e.b = d; e.req = {"R5/", ctx};
      end
    end
    q.push_back(e);
    if (m_pos < FRAME) m_pos++;
    if (we) begin
      if (a == 2'd3) m_pcode = data;
      else if (ba && bb) m_pmask[a*8 +: 8] = data;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] data, input logic ba, input logic bb);
    cyc(1'($urandom), 1'b0, 1'b1, a, data, ba, bb);
  endtask

  task automatic idle_bits(input int n);
    for (int i = 0; i < n; i++) cyc(1'($urandom), 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic frame(input int wr_at, input logic [1:0] a, input logic [7:0] data,
                       input logic ba, input logic bb);
    for (int i = 0; i < FRAME; i++)
      cyc(1'($urandom), i == 0, i == wr_at, a, data, ba, bb);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(dout, e.b, e.req);
      check(dout_fs, e.fs, {"R2/", e.req});
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(dout, 1'b0, "R1 dout in reset");
    check(dout_fs, 1'b0, "R1 dout_fs in reset");
    @(negedge clk);
    rst_n = 1'b1;
    ctx = "R1"; frame(-1, 2'd0, 8'h00, 1'b0, 1'b0);
    ctx = "R9"; idle_bits(5);
    wr(2'd3, 8'hA5, 1'b0, 1'b0);
    wr(2'd0, 8'hFF, 1'b1, 1'b1);
    wr(2'd1, 8'hFF, 1'b1, 1'b1);
    wr(2'd2, 8'hFF, 1'b1, 1'b1);
    idle_bits(20);
    ctx = "R6"; frame(-1, 2'd0, 8'h00, 1'b0, 1'b0);
    wr(2'd0, 8'h01, 1'b1, 1'b1);
    wr(2'd1, 8'h00, 1'b1, 1'b1);
    wr(2'd2, 8'h80, 1'b1, 1'b1);
    ctx = "R6 ends"; frame(-1, 2'd0, 8'h00, 1'b0, 1'b0);
    wr(2'd1, 8'hFF, 1'b1, 1'b0);
    wr(2'd2, 8'h00, 1'b0, 1'b1);
    wr(2'd0, 8'hFE, 1'b0, 1'b0);
    wr(2'd3, 8'h3C, 1'b0, 1'b0);
    ctx = "R7"; frame(-1, 2'd0, 8'h00, 1'b0, 1'b0);
    ctx = "R8 mask"; frame(100, 2'd1, 8'hF0, 1'b1, 1'b1);
    ctx = "R8 after"; frame(50, 2'd3, 8'h96, 1'b0, 1'b0);
    ctx = "R8 code"; frame(-1, 2'd0, 8'h00, 1'b0, 1'b0);
    wr(2'd0, 8'h55, 1'b1, 1'b1);
    wr(2'd1, 8'hAA, 1'b1, 1'b1);
    wr(2'd2, 8'h55, 1'b1, 1'b1);
    wr(2'd3, 8'h00, 1'b1, 1'b1);
    ctx = "R4 alt"; frame(-1, 2'd0, 8'h00, 1'b0, 1'b0);
    wr(2'd3, 8'hFF, 1'b0, 1'b0);
    ctx = "R4 ones"; frame(-1, 2'd0, 8'h00, 1'b0, 1'b0);
    ctx = "R9 tail"; idle_bits(40);
    wr(2'd0, 8'h00, 1'b1, 1'b1);
    wr(2'd1, 8'h00, 1'b1, 1'b1);
    wr(2'd2, 8'h00, 1'b1, 1'b1);
    ctx = "R5 clear"; frame(-1, 2'd0, 8'h00, 1'b0, 1'b0);
    idle_bits(2);
    @(negedge clk);
    @(negedge clk);
    finish_up();
  end
endmodule